// File: doc/BRIEF.md
# Armed SPI Slave Transaction Engine

This block is a full-duplex SPI slave. It lives in a system clock domain that runs much faster than the serial clock, and it oversamples the serial clock, the chip select and the data-in line. Between transactions, local logic fills a transmit buffer through a simple write port and picks a transfer limit and an SPI mode. It then pulses `arm`. The block raises `ready` so that the master knows it may open a chip-select window. Exactly one transaction is exchanged per window.

During the window, each serial clock pulse moves one bit in each direction, most-significant bit first. Every completed received byte is stored in a receive buffer at an address that increases by one per byte. Local logic reads that buffer through a combinational read port. The configured limit caps how many bits are taken from the transmit buffer and stored into the receive buffer. The master alone decides how long the window really is.

When chip select rises, the block pulses `done` for one cycle and reports how many bits were exchanged, clamped to the limit. It drops `ready` and stays idle until it is armed again.

Top module: `spi_armed_slave`

## Requirements
- R1: After reset, `ready`, `done` and `spi_miso` are 0.
- R2: A one-cycle `arm` while `spi_cs_n` is high sets `ready` on the next cycle. The block latches `mode` and the limit, which is `cfg_len` clamped to DEPTH*8 bits.
- R3: Received bits are assembled MSB first. Received byte k (bits 8k to 8k+7 of the window) is written to receive buffer address k. A partial final byte is not written.
- R4: Transmitted bit i of the window is bit 7-(i mod 8) of transmit buffer byte i/8.
- R5: `mode` bit 1 is the clock idle level and bit 0 is the phase. With phase 0, bits are sampled on the leading clock edge and driven on the trailing edge, and the first bit appears on `spi_miso` after chip select falls, before any clock edge. With phase 1, bits are driven on the leading edge and sampled on the trailing edge.
- R6: When the master clocks more bits than the limit, the extra bits do not change the receive buffer, `spi_miso` is 0 for them, and `xfer_bits` equals the limit.
- R7: When the master clocks fewer bits than the limit, `xfer_bits` equals the number of bits clocked.
- R8: On the rising edge of chip select, `done` is high for exactly one cycle with `xfer_bits` valid, and `ready` goes low. A later window without a new `arm` produces no `done`.
- R9: A chip-select window while the block is not armed leaves the receive buffer unchanged and keeps `spi_miso` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sclk | input | 1 | Serial clock from the master |
| spi_cs_n | input | 1 | Active-low chip select from the master |
| spi_mosi | input | 1 | Serial data from the master |
| spi_miso | output | 1 | Serial data to the master |
| ready | output | 1 | High while armed; the master may start a window |
| arm | input | 1 | Request to arm for one transaction |
| mode | input | 2 | SPI mode: bit 1 clock idle level, bit 0 phase |
| cfg_len | input | AW+4 | Transfer limit in bits |
| tx_we | input | 1 | Transmit buffer write enable |
| tx_addr | input | AW | Transmit buffer byte address |
| tx_wdata | input | 8 | Transmit buffer write data |
| rx_addr | input | AW | Receive buffer byte address |
| rx_rdata | output | 8 | Receive buffer read data (combinational) |
| done | output | 1 | One-cycle completion pulse |
| xfer_bits | output | AW+4 | Bits exchanged in the last transaction, clamped |

## Verification
The assertions assume that the master holds the serial clock at the idle level of the armed mode whenever chip select changes. They also assume that each serial clock phase lasts several system clock cycles, so edges of the clock and of chip select never fall in the same sampled cycle. The bench keeps every half period at eight system cycles and parks the clock at the idle level before it arms the block and around every chip-select edge. It sweeps all four modes against transaction lengths below, equal to and above several limits, including a limit clamped to the full buffer.

// File: rtl/spi_armed_slave.sv
module spi_armed_slave #(
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH),
  localparam int LW = AW + 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          spi_sclk,
  input  logic          spi_cs_n,
  input  logic          spi_mosi,
  output logic          spi_miso,
  output logic          ready,
  input  logic          arm,
  input  logic [1:0]    mode,
  input  logic [LW-1:0] cfg_len,
  input  logic          tx_we,
  input  logic [AW-1:0] tx_addr,
  input  logic [7:0]    tx_wdata,
  input  logic [AW-1:0] rx_addr,
  output logic [7:0]    rx_rdata,
  output logic          done,
  output logic [LW-1:0] xfer_bits
);
  localparam logic [LW-1:0] MAXBITS = LW'(DEPTH * 8);

  logic [7:0] txmem [DEPTH];
  logic [7:0] rxmem [DEPTH];

  logic sclk_m, sclk_s, sclk_p;
  logic cs_m, cs_s, cs_p;
  logic mosi_m, mosi_s;

  logic          armed, active, cpol_q, cpha_q;
  logic [LW-1:0] len_q, bitcnt, ptr;
  logic [6:0]    rx_sh;

  wire sclk_chg = sclk_s ^ sclk_p;
  wire lead     = sclk_chg & (sclk_s != cpol_q);
  wire trail    = sclk_chg & (sclk_s == cpol_q);
  wire samp     = cpha_q ? trail : lead;
  wire launch   = cpha_q ? lead : trail;
  wire cs_fall  = cs_p & ~cs_s;
  wire cs_rise  = ~cs_p & cs_s;
  wire take     = active & ~cs_rise & samp & (bitcnt < len_q);
  wire [2:0] tx_bit = 3'd7 - ptr[2:0];

  assign ready    = armed;
  assign rx_rdata = rxmem[rx_addr];
  assign spi_miso = active & (ptr < len_q) & txmem[ptr[AW+2:3]][tx_bit];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {sclk_m, sclk_s, sclk_p} <= '0;
      {cs_m, cs_s, cs_p} <= '1;
      {mosi_m, mosi_s} <= '0;
    end else begin
      {sclk_m, sclk_s, sclk_p} <= {spi_sclk, sclk_m, sclk_s};
      {cs_m, cs_s, cs_p} <= {spi_cs_n, cs_m, cs_s};
      {mosi_m, mosi_s} <= {spi_mosi, mosi_m};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed <= 1'b0;
      active <= 1'b0;
      cpol_q <= 1'b0;
      cpha_q <= 1'b0;
      len_q <= '0;
      bitcnt <= '0;
      ptr <= '0;
      rx_sh <= '0;
      done <= 1'b0;
      xfer_bits <= '0;
    end else begin
      done <= 1'b0;
      if (!armed) begin
        if (arm && cs_s) begin
          armed <= 1'b1;
          {cpol_q, cpha_q} <= mode;
          len_q <= (cfg_len > MAXBITS) ? MAXBITS : cfg_len;
        end
      end else if (!active) begin
        if (cs_fall) begin
          active <= 1'b1;
          bitcnt <= '0;
          ptr <= '0;
        end
      end else if (cs_rise) begin
        done <= 1'b1;
        xfer_bits <= bitcnt;
        armed <= 1'b0;
        active <= 1'b0;
      end else begin
        if (take) begin
          rx_sh <= {rx_sh[5:0], mosi_s};
          bitcnt <= bitcnt + 1'b1;
        end
        if (launch) ptr <= bitcnt;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (tx_we) txmem[tx_addr] <= tx_wdata;
    if (take && bitcnt[2:0] == 3'd7) rxmem[bitcnt[AW+2:3]] <= {rx_sh, mosi_s};
  end

  assert_reset_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |-> !spi_miso);

  assert_arm_ready_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed && arm && cs_s) |=> ready);

  assert_cnt_cap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> bitcnt <= len_q);

  assert_len_cap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> xfer_bits <= len_q);

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_ready_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !ready);

  assert_idle_miso_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> !spi_miso);
endmodule

// File: tb/sim_spi_armed_slave.sv
module sim_spi_armed_slave;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 64;
  localparam int AW = $clog2(DEPTH);
  localparam int LW = AW + 4;
  localparam int H = 8;

  logic clk = 0, rst_n = 0;
  logic spi_sclk = 0, spi_cs_n = 1, spi_mosi = 0, arm = 0, tx_we = 0;
  logic [1:0] mode = 0;
  logic [LW-1:0] cfg_len = 0;
  logic [AW-1:0] tx_addr = 0, rx_addr = 0;
  logic [7:0] tx_wdata = 0;
  logic spi_miso, ready, done;
  logic [7:0] rx_rdata;
  logic [LW-1:0] xfer_bits;

  int checks = 0, failures = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_armed_slave #(.DEPTH(DEPTH)) u0 (
    .clk(clk), .rst_n(rst_n), .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso), .ready(ready), .arm(arm),
    .mode(mode), .cfg_len(cfg_len), .tx_we(tx_we), .tx_addr(tx_addr),
    .tx_wdata(tx_wdata), .rx_addr(rx_addr), .rx_rdata(rx_rdata),
    .done(done), .xfer_bits(xfer_bits));

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] txpat(input int k, input int m);
    return 8'(k * 37 + m * 11 + 5);
  endfunction

  function automatic logic [7:0] mpat(input int k, input int m);
    return 8'(k * 53 + m * 29 + 91);
  endfunction

  task automatic waitc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic xfer(input int m, input int n, input int c, input bit do_arm);
    logic [7:0] pre [DEPTH];
    int eff, exp_len, miso_err, rx_err, done_cnt, got_len;
    bit cpol, cpha;
    cpol = m[1];
    cpha = m[0];
    for (int k = 0; k < DEPTH; k++) begin
      tx_we = 1; tx_addr = AW'(k); tx_wdata = txpat(k, m);
      waitc(1);
    end
    tx_we = 0;
    spi_sclk = cpol;
    waitc(4);
    for (int k = 0; k < DEPTH; k++) begin
      rx_addr = AW'(k); #1; pre[k] = rx_rdata;
    end
    if (do_arm) begin
      arm = 1; cfg_len = LW'(c); mode = 2'(m);
      waitc(1);
      arm = 0;
      check(ready === 1'b1, "R2 ready after arm", int'(ready), 1);
    end
    eff = do_arm ? ((c > DEPTH * 8) ? DEPTH * 8 : c) : 0;
    exp_len = (n < eff) ? n : eff;
    miso_err = 0;
    spi_cs_n = 0;
    spi_mosi = cpha ? 1'b0 : mpat(0, m)[7];
    waitc(H);
    for (int i = 0; i < n; i++) begin
      logic expb;
      expb = (i < eff) ? txpat(i / 8, m)[7 - i % 8] : 1'b0;
      spi_sclk = ~cpol;
      if (!cpha) begin
        if (spi_miso !== expb) miso_err++;
      end else spi_mosi = mpat(i / 8, m)[7 - i % 8];
      waitc(H);
      spi_sclk = cpol;
      if (cpha) begin
        if (spi_miso !== expb) miso_err++;
      end else spi_mosi = mpat((i + 1) / 8, m)[7 - (i + 1) % 8];
      waitc(H);
    end
    spi_cs_n = 1;
    done_cnt = 0; got_len = -1;
    for (int t = 0; t < 16; t++) begin
      waitc(1);
      if (done === 1'b1) begin done_cnt++; got_len = int'(xfer_bits); end
    end
    rx_err = 0;
    for (int k = 0; k < DEPTH; k++) begin
      logic [7:0] e;
      e = (k < exp_len / 8) ? mpat(k, m) : pre[k];
      rx_addr = AW'(k); #1;
      if (rx_rdata !== e) rx_err++;
    end
    if (do_arm) begin
      check(miso_err == 0, "R4 R5 R6 miso bits", miso_err, 0);
      check(rx_err == 0, "R3 R6 rx buffer", rx_err, 0);
      check(done_cnt == 1, "R8 single done pulse", done_cnt, 1);
      check(got_len == exp_len, (n > eff) ? "R6 clamped length" : "R7 actual length",
            got_len, exp_len);
      check(ready === 1'b0, "R8 ready low after done", int'(ready), 0);
    end else begin
      check(miso_err == 0, "R9 miso idle unarmed", miso_err, 0);
      check(rx_err == 0, "R9 rx unchanged unarmed", rx_err, 0);
      check(done_cnt == 0, "R8 no done without arm", done_cnt, 0);
    end
  endtask

  initial begin
    int lens [4];
    int cfgs [3];
    lens = '{8, 16, 40, 64};
    cfgs = '{16, 40, 1000};
    waitc(3);
    check(ready === 1'b0, "R1 ready reset", int'(ready), 0);
    check(done === 1'b0, "R1 done reset", int'(done), 0);
    check(spi_miso === 1'b0, "R1 miso reset", int'(spi_miso), 0);
    rst_n = 1;
    waitc(3);
    for (int m = 0; m < 4; m++) begin
      foreach (lens[i]) foreach (cfgs[j]) xfer(m, lens[i], cfgs[j], 1'b1);
      xfer(m, 24, 24, 1'b0);
    end
    xfer(0, DEPTH * 8 + 8, 1000, 1'b1);
    xfer(3, 13, 1000, 1'b1);
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; failures++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule